// File: doc/BRIEF.md
# Memory Fault Capture and Interrupt Unit

This unit sits beside a memory controller and keeps a record of faulting requests. The controller reports three kinds of fault, each on its own pulse input: an address that decodes to no memory, an access to an invalid translation page, and a security violation. Each pulse comes with the attributes of the request: the requesting client, whether it was a write, a violation kind and the faulting address. For each fault kind, the unit keeps only the first fault that arrives after its pending bit was last cleared. It raises one interrupt line for every pending kind that software has enabled.

Software reads and writes the unit through a simple register port. Writes take effect on the clock edge and reads are combinational. Every fault kind has a status word with its own bit layout, and the faulting address is one word above it. Software reads the record, then writes a one to the matching bit of the pending register to clear it, and that lets the next fault of that kind be captured.

Top module: `mem_err_logger`

## Requirements
- R1: After reset, every register reads zero and `irq_o` is low.
- R2: A pulse on `err_vld_i[k]` while kind k is not pending sets pending bit k and records the request. The record is visible from the clock edge that samples the pulse. Kind 0 is decode, kind 1 is translation, kind 2 is security.
- R3: While kind k is pending and is not being cleared, further pulses of kind k leave its status word and address unchanged.
- R4: The decode status word, at offset 0x10, holds the client in bits 5:0 and the write flag in bit 31. All other bits are zero.
- R5: The translation status word, at offset 0x18, holds the write flag in bit 0 and the client in bits 6:1. All other bits are zero.
- R6: The security status word, at offset 0x20, holds the client in bits 5:0, the violation kind in bit 30 and the write flag in bit 31. All other bits are zero.
- R7: The captured faulting address of each kind reads at that kind's status offset plus 4.
- R8: Only the low 6 bits of the 8-bit client input are kept.
- R9: The pending register at offset 0x00 has one bit per kind, at bit k. Writing a one to a bit clears it, and writing a zero has no effect.
- R10: The enable register at offset 0x04 is read/write in bits 2:0. `irq_o` is high exactly when some pending bit has its enable bit set. Pending bits are set whether or not they are enabled.
- R11: A fault of kind k in the same cycle as a write that clears bit k is captured, and bit k stays set.
- R12: Writes to the status or address words, or to unmapped offsets, change nothing. Reads of unmapped offsets return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| err_vld_i | input | 3 | Fault pulse per kind (0 decode, 1 translation, 2 security) |
| err_client_i | input | 24 | 8-bit client per kind, kind k at bits 8k+7:8k |
| err_write_i | input | 3 | Write flag per kind |
| err_kind_i | input | 3 | Violation kind per fault kind (used by security only) |
| err_addr_i | input | 96 | 32-bit faulting address per kind, kind k at bits 32k+31:32k |
| reg_wen_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for `reg_addr_i` |
| irq_o | output | 1 | Interrupt, OR of enabled pending bits |

## Verification
The assertions assume the inputs are known and steady around each rising edge. They also assume that `irq_o` can rise only after a fault pulse or a register write in the previous cycle, so they treat the error and write strobes as the only sources of change. The stimulus drives all inputs on the falling edge, leaves the strobes idle between operations, and draws random fault mixes and register writes from a fixed seed. It often aims writes at the pending and enable registers, so that a fault and a clear of the same kind collide in the same cycle.

// File: rtl/mel_pkg.sv
`timescale 1ns/1ps
package mel_pkg;
    localparam int N_KIND    = 3;
    localparam int CLI_IN_W  = 8;
    localparam int CLI_W     = 6;
    localparam int DATA_W    = 32;
    localparam int FADDR_W   = 32;
    localparam int RADDR_W   = 8;

    localparam logic [CLI_IN_W-1:0] CLI_MASK = CLI_IN_W'(8'h3F);

    localparam logic [RADDR_W-1:0] OFS_PEND  = 8'h00;
    localparam logic [RADDR_W-1:0] OFS_ENAB  = 8'h04;
    localparam logic [RADDR_W-1:0] OFS_REC0  = 8'h10;
    localparam int                 REC_STEP  = 8;
    localparam int                 ADDR_GAP  = 4;

    localparam int KIND_DEC = 0;
    localparam int KIND_TRN = 1;
    localparam int KIND_SEC = 2;

    typedef struct packed {
        logic               pend;
        logic [CLI_W-1:0]   cli;
        logic               wr;
        logic               kind;
        logic [FADDR_W-1:0] addr;
    } rec_t;

    function automatic logic [RADDR_W-1:0] stat_ofs(input int k);
        return OFS_REC0 + RADDR_W'(k * REC_STEP);
    endfunction

    function automatic logic [RADDR_W-1:0] addr_ofs(input int k);
        return stat_ofs(k) + RADDR_W'(ADDR_GAP);
    endfunction
endpackage

// File: rtl/mel_capture_slot.sv
`timescale 1ns/1ps
module mel_capture_slot
    import mel_pkg::*;
#(
    parameter int KIND = KIND_DEC
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                err_vld_i,
    input  logic [CLI_IN_W-1:0] err_client_i,
    input  logic                err_write_i,
    input  logic                err_kind_i,
    input  logic [FADDR_W-1:0]  err_addr_i,
    input  logic                clr_i,
    output logic                pend_o,
    output logic [DATA_W-1:0]   stat_word_o,
    output logic [FADDR_W-1:0]  addr_o
);
    rec_t rec_d, rec_q;
    logic take;

    always_comb begin
        rec_d = rec_q;
        take  = err_vld_i && (!rec_q.pend || clr_i);
        if (take) begin
            rec_d.pend = 1'b1;
            rec_d.cli  = CLI_W'(err_client_i & CLI_MASK);
            rec_d.wr   = err_write_i;
            rec_d.kind = (KIND == KIND_SEC) ? err_kind_i : 1'b0;
            rec_d.addr = err_addr_i;
        end else if (clr_i) begin
            rec_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rec_q <= '0;
        else        rec_q <= rec_d;
    end

    generate
        if (KIND == KIND_TRN) begin : g_trn_fmt
            always_comb begin
                stat_word_o               = '0;
                stat_word_o[0]            = rec_q.wr;
                stat_word_o[CLI_W:1]      = rec_q.cli;
            end
        end else if (KIND == KIND_SEC) begin : g_sec_fmt
            always_comb begin
                stat_word_o               = '0;
                stat_word_o[CLI_W-1:0]    = rec_q.cli;
                stat_word_o[30]           = rec_q.kind;
                stat_word_o[31]           = rec_q.wr;
            end
        end else begin : g_dec_fmt
            always_comb begin
                stat_word_o               = '0;
                stat_word_o[CLI_W-1:0]    = rec_q.cli;
                stat_word_o[31]           = rec_q.wr;
            end
        end
    endgenerate

    assign pend_o = rec_q.pend;
    assign addr_o = rec_q.addr;

    // R2
    capture_sets_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_vld_i |=> pend_o);

    // R3
    hold_while_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_o && !clr_i) |=> ($stable(stat_word_o) && $stable(addr_o)));

    // R9
    clear_drops_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !err_vld_i) |=> !pend_o);

    // R11
    clear_vs_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && err_vld_i) |=> (pend_o && addr_o == $past(err_addr_i)));
endmodule

// File: rtl/mel_ctrl_regs.sv
`timescale 1ns/1ps
module mel_ctrl_regs
    import mel_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               reg_wen_i,
    input  logic [RADDR_W-1:0] reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    input  logic [N_KIND-1:0]  pend_i,
    output logic [N_KIND-1:0]  clr_o,
    output logic [N_KIND-1:0]  enab_o,
    output logic               irq_o
);
    typedef struct packed {
        logic [N_KIND-1:0] enab;
        logic              irq;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        clr_o = '0;
        if (reg_wen_i && reg_addr_i == OFS_PEND)
            clr_o = reg_wdata_i[N_KIND-1:0];
        if (reg_wen_i && reg_addr_i == OFS_ENAB)
            ctl_d.enab = reg_wdata_i[N_KIND-1:0];
        ctl_d.irq = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign enab_o = ctl_q.enab;
    assign irq_o  = |(pend_i & ctl_q.enab);

    // R10
    enab_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wen_i && reg_addr_i == OFS_ENAB) |=> enab_o == $past(reg_wdata_i[N_KIND-1:0]));
endmodule

// File: rtl/mel_read_mux.sv
`timescale 1ns/1ps
module mel_read_mux
    import mel_pkg::*;
(
    input  logic [RADDR_W-1:0]        addr_i,
    input  logic [N_KIND-1:0]         pend_i,
    input  logic [N_KIND-1:0]         enab_i,
    input  logic [N_KIND*DATA_W-1:0]  stat_i,
    input  logic [N_KIND*FADDR_W-1:0] faddr_i,
    output logic [DATA_W-1:0]         rdata_o
);
    always_comb begin
        rdata_o = '0;
        if (addr_i == OFS_PEND) rdata_o[N_KIND-1:0] = pend_i;
        if (addr_i == OFS_ENAB) rdata_o[N_KIND-1:0] = enab_i;
        for (int k = 0; k < N_KIND; k++) begin
            if (addr_i == stat_ofs(k)) rdata_o = stat_i[k*DATA_W +: DATA_W];
            if (addr_i == addr_ofs(k)) rdata_o = DATA_W'(faddr_i[k*FADDR_W +: FADDR_W]);
        end
    end
endmodule

// File: rtl/mem_err_logger.sv
`timescale 1ns/1ps
module mem_err_logger
    import mel_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_KIND-1:0]            err_vld_i,
    input  logic [N_KIND*CLI_IN_W-1:0]   err_client_i,
    input  logic [N_KIND-1:0]            err_write_i,
    input  logic [N_KIND-1:0]            err_kind_i,
    input  logic [N_KIND*FADDR_W-1:0]    err_addr_i,
    input  logic                         reg_wen_i,
    input  logic [RADDR_W-1:0]           reg_addr_i,
    input  logic [DATA_W-1:0]            reg_wdata_i,
    output logic [DATA_W-1:0]            reg_rdata_o,
    output logic                         irq_o
);
    logic [N_KIND-1:0]         pend, clr, enab;
    logic [N_KIND*DATA_W-1:0]  stat;
    logic [N_KIND*FADDR_W-1:0] faddr;

    generate
        for (genvar k = 0; k < N_KIND; k++) begin : g_slot
            mel_capture_slot #(.KIND(k)) u_slot (
                .clk          (clk),
                .rst_n        (rst_n),
                .err_vld_i    (err_vld_i[k]),
                .err_client_i (err_client_i[k*CLI_IN_W +: CLI_IN_W]),
                .err_write_i  (err_write_i[k]),
                .err_kind_i   (err_kind_i[k]),
                .err_addr_i   (err_addr_i[k*FADDR_W +: FADDR_W]),
                .clr_i        (clr[k]),
                .pend_o       (pend[k]),
                .stat_word_o  (stat[k*DATA_W +: DATA_W]),
                .addr_o       (faddr[k*FADDR_W +: FADDR_W])
            );
        end
    endgenerate

    mel_ctrl_regs u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .reg_wen_i   (reg_wen_i),
        .reg_addr_i  (reg_addr_i),
        .reg_wdata_i (reg_wdata_i),
        .pend_i      (pend),
        .clr_o       (clr),
        .enab_o      (enab),
        .irq_o       (irq_o)
    );

    mel_read_mux u_rmux (
        .addr_i  (reg_addr_i),
        .pend_i  (pend),
        .enab_i  (enab),
        .stat_i  (stat),
        .faddr_i (faddr),
        .rdata_o (reg_rdata_o)
    );

    // R10
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(|err_vld_i) || $past(reg_wen_i)));

    // R10
    irq_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (enab == '0) |-> !irq_o);
endmodule

// File: tb/tb_mem_err_logger.sv
`timescale 1ns/1ps
module tb_mem_err_logger;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  err_vld = '0;
    logic [23:0] err_client = '0;
    logic [2:0]  err_write = '0;
    logic [2:0]  err_kind = '0;
    logic [95:0] err_addr = '0;
    logic        reg_wen = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int n_run = 0, n_fail = 0;
    bit done = 0;

    logic [2:0]  m_pend = '0, m_enab = '0;
    logic [5:0]  m_cli [3];
    logic        m_wr [3], m_knd [3];
    logic [31:0] m_fa [3];

    always #5 clk = ~clk;

    mem_err_logger dut (
        .clk(clk), .rst_n(rst_n), .err_vld_i(err_vld), .err_client_i(err_client),
        .err_write_i(err_write), .err_kind_i(err_kind), .err_addr_i(err_addr),
        .reg_wen_i(reg_wen), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
        .reg_rdata_o(reg_rdata), .irq_o(irq)
    );

    function automatic logic [31:0] exp_stat(int k);
        logic [31:0] w = '0;
        if (k == 1) begin
            w[0] = m_wr[k]; w[6:1] = m_cli[k];
        end else begin
            w[5:0] = m_cli[k]; w[31] = m_wr[k];
            if (k == 2) w[30] = m_knd[k];
        end
        return w;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        reg_addr = a;
        #0.4;
        d = reg_rdata;
    endtask

    task automatic check_all();
        logic [31:0] d;
        string rq;
        rd(8'h00, d); check("R9 pending", d, {29'd0, m_pend});
        rd(8'h04, d); check("R10 enable", d, {29'd0, m_enab});
        for (int k = 0; k < 3; k++) begin
            rq = (k == 0) ? "R4" : (k == 1) ? "R5" : "R6";
            rd(8'h10 + 8'(8*k), d); check(rq, d, exp_stat(k));
            rd(8'h14 + 8'(8*k), d); check("R7 addr", d, m_fa[k]);
        end
        check("R10 irq", {31'd0, irq}, {31'd0, |(m_pend & m_enab)});
    endtask

    task automatic step(logic [2:0] v, logic [23:0] cl, logic [2:0] w, logic [2:0] t,
                        logic [95:0] a, logic we, logic [7:0] wa, logic [31:0] wd);
        logic [2:0] clr;
        err_vld = v; err_client = cl; err_write = w; err_kind = t; err_addr = a;
        reg_wen = we; reg_addr = wa; reg_wdata = wd;
        @(posedge clk);
        clr = (we && wa == 8'h00) ? wd[2:0] : 3'b0;
        for (int k = 0; k < 3; k++) begin
            if (v[k] && (!m_pend[k] || clr[k])) begin
                m_pend[k] = 1'b1;
                m_cli[k]  = cl[k*8 +: 6];
                m_wr[k]   = w[k];
                m_knd[k]  = (k == 2) ? t[k] : 1'b0;
                m_fa[k]   = a[k*32 +: 32];
            end else if (clr[k]) m_pend[k] = 1'b0;
        end
        if (we && wa == 8'h04) m_enab = wd[2:0];
        @(negedge clk);
        err_vld = '0; reg_wen = 1'b0;
        check_all();
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++; n_run++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        logic [7:0] wa;
        int seed;
        seed = 7;
        void'($urandom(seed));
        for (int k = 0; k < 3; k++) begin
            m_cli[k] = '0; m_wr[k] = 0; m_knd[k] = 0; m_fa[k] = '0;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd(8'h00, d); check("R1 pending", d, 0);
        rd(8'h04, d); check("R1 enable", d, 0);
        rd(8'h10, d); check("R1 status", d, 0);
        rd(8'h24, d); check("R1 addr", d, 0);
        check("R1 irq", {31'd0, irq}, 0);

        // R2/R8/R4: decode fault with client input 0xFF, masked
        step(3'b001, 24'h0000FF, 3'b001, 3'b000, {64'd0, 32'hDEAD_0001}, 0, 0, 0);
        rd(8'h10, d); check("R8 client mask", d, 32'h8000_003F);
        check("R2 pending set, masked irq low", {31'd0, irq}, 0);
        // R3: second decode fault ignored
        step(3'b001, 24'h000012, 3'b000, 3'b000, {64'd0, 32'h1234_5678}, 0, 0, 0);
        rd(8'h14, d); check("R3 addr held", d, 32'hDEAD_0001);
        // R5: translation write from client 0x2A
        step(3'b010, 24'h002A00, 3'b010, 3'b000, {32'd0, 32'hCAFE_0000, 32'd0}, 0, 0, 0);
        rd(8'h18, d); check("R5 translation word", d, 32'h0000_0055);
        // R6: security read, kind 1, client 0x05
        step(3'b100, 24'h050000, 3'b000, 3'b100, {32'h0BAD_F00D, 64'd0}, 0, 0, 0);
        rd(8'h20, d); check("R6 security word", d, 32'h4000_0005);
        // R10: enable security only
        step(0, 0, 0, 0, 0, 1, 8'h04, 32'hFFFF_FFFC);
        check("R10 irq on", {31'd0, irq}, 1);
        // R9: writing zeros has no effect, then clear bit 2
        step(0, 0, 0, 0, 0, 1, 8'h00, 32'h0);
        rd(8'h00, d); check("R9 zero write", d, 32'h7);
        step(0, 0, 0, 0, 0, 1, 8'h00, 32'h4);
        check("R9 cleared irq", {31'd0, irq}, 0);
        // R11: clear and new fault same cycle on decode
        step(3'b001, 24'h000003, 3'b000, 3'b000, {64'd0, 32'h0000_ABCD}, 1, 8'h00, 32'h1);
        rd(8'h14, d); check("R11 recaptured", d, 32'h0000_ABCD);
        // R12: writes to RO and unmapped offsets ignored; unmapped reads zero
        step(0, 0, 0, 0, 0, 1, 8'h14, 32'h5555_5555);
        step(0, 0, 0, 0, 0, 1, 8'h3C, 32'hFFFF_FFFF);
        rd(8'h14, d); check("R12 RO addr", d, 32'h0000_ABCD);
        rd(8'h3C, d); check("R12 unmapped read", d, 0);
        rd(8'h08, d); check("R12 unmapped read", d, 0);

        // random phase
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r;
            r = $urandom;
            case (r[2:0])
                3'd0, 3'd1, 3'd2: wa = 8'h00;
                3'd3:             wa = 8'h04;
                3'd4:             wa = 8'h10 + 8'($urandom_range(0, 5) * 4);
                default:          wa = 8'($urandom);
            endcase
            step(3'($urandom) & 3'($urandom), 24'($urandom), 3'($urandom), 3'($urandom),
                 {$urandom, $urandom, $urandom}, r[8] & r[9], wa, $urandom);
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule